// File: doc/BRIEF.md
# Acquisition Trigger Gating Controller

This block decides the cycles in which a data-acquisition converter begins collecting a sample. A pulse-trigger line is brought into the clock domain through a two-flop synchronizer and its rising edge is detected. That edge is accepted only while a measurement-ready (arm) input is high and the block is idle. An accepted edge starts a burst of back-to-back samples. Each sample is modelled as a fixed-length busy interval that opens with a one-cycle start strobe.

The length of a burst depends on the sweep configuration. In step mode a trigger normally covers one averaged point, which is every sub-point of that point. When the per-sub-point trigger bit is set, a trigger covers a single sub-point. In continuous-wave mode a trigger runs all the remaining points of the sweep. Internal sub-point and point counters track the position in the sweep. A one-cycle sweep-done pulse marks the end of the last point, and the position then returns to the sweep start.

When the pulse-trigger enable is low, acquisition is not tied to the pulse line: the arm input alone starts a burst whenever the block is idle. With the trigger source held internal, the arm input is simply tied high and the pulse line paces acquisition. All control and status pins are plain levels or strobes. There is no data stream and no back-pressure. The configuration inputs must stay stable while a sweep is in progress.

Top module: `acq_trig_gate`

## Requirements
- R1: While enabled, a pulse-line rising edge starts a burst when arm is high in the cycle the synchronized edge is evaluated. With default parameters, start_o rises 3 clock edges after the edge that first samples p0_i high. Arm raised in the same cycle as p0_i is accepted.
- R2: A pulse edge evaluated while arm is low is discarded. Raising arm afterwards, with p0_i staying low, starts nothing, and the sweep position is unchanged.
- R3: Once a burst has started it runs to completion regardless of p0_i or arm_i. The width of the p0_i pulse has no effect: a long pulse gives exactly one burst.
- R4: Each sample asserts start_o for exactly one cycle, in its first busy cycle. busy_o stays high for SAMPLE_LEN cycles per sample. The samples of a burst follow each other with no gap.
- R5: In step mode (cw_mode_i=0) with subpt_trig_i=0, one trigger acquires the remaining sub-points of the current point. A full point is avg_cnt_i samples, and an avg_cnt_i value of 0 is treated as 1.
- R6: In step mode with subpt_trig_i=1, each trigger acquires exactly one sample.
- R7: In continuous-wave mode (cw_mode_i=1), one trigger acquires every remaining sample of the sweep. From the sweep start this is points × sub-points samples.
- R8: With p0_en_i=0, p0_i is ignored and a high arm_i alone starts a burst in the next cycle whenever the block is idle. A low arm_i starts nothing.
- R9: Pulse edges evaluated while busy_o is high are ignored and start no later burst.
- R10: sweep_done_o is a one-cycle pulse in the first cycle after the last sample of the sweep, with busy_o low. The position then returns to the sweep start. A point count (num_pts_i) of 0 is treated as 1.
- R11: After reset, start_o, busy_o and sweep_done_o are low and the position is at the sweep start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Measurement-ready level |
| p0_i | input | 1 | Asynchronous pulse-trigger line |
| p0_en_i | input | 1 | 1: bursts need a pulse edge; 0: arm alone starts bursts |
| cw_mode_i | input | 1 | 1: one trigger per sweep; 0: step mode |
| subpt_trig_i | input | 1 | Step mode: 1 gives one sample per trigger |
| avg_cnt_i | input | AVG_W | Sub-points per point (0 treated as 1) |
| num_pts_i | input | PTS_W | Points per sweep (0 treated as 1) |
| start_o | output | 1 | One-cycle strobe at each sample start |
| busy_o | output | 1 | High while samples are being collected |
| sweep_done_o | output | 1 | One-cycle pulse after the last sample of a sweep |

## Verification
The embedded properties check, on every cycle, that:
- a burst only opens after a cycle with arm high and, when enabled, a synchronized edge;
- start strobes only appear inside busy;
- busy only falls on an expired sample timer;
- sweep-done is a lone pulse outside busy;
- the position wraps to zero at sweep end.

Burst lengths per mode, the discarding of edges that arrive unarmed or during busy, the insensitivity to pulse width, and the exact start latency depend on whole scenarios. Only the bench's trigger sequences can show these, measured against a position model that it keeps itself.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SAMPLE = 1'b1
  } acq_state_e;
endpackage

// File: rtl/acq_p0_sync.sv
module acq_p0_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic p0_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], p0_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign edge_o = chain_q[STAGES-1] & ~prev_q;

  // R1
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/acq_pos_ctr.sv
module acq_pos_ctr #(
  parameter int AVG_W = 4,
  parameter int PTS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  logic [AVG_W-1:0] avg_i,
  input  logic [PTS_W-1:0] npts_i,
  output logic             last_sub_o,
  output logic             last_pt_o
);
  logic [AVG_W-1:0] sub_q;
  logic [PTS_W-1:0] pt_q;
  logic [AVG_W-1:0] sub_top;
  logic [PTS_W-1:0] pt_top;

  assign sub_top    = (avg_i  == '0) ? '0 : avg_i  - 1'b1;
  assign pt_top     = (npts_i == '0) ? '0 : npts_i - 1'b1;
  assign last_sub_o = (sub_q >= sub_top);
  assign last_pt_o  = (pt_q  >= pt_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
      pt_q  <= '0;
    end else if (advance_i) begin
      if (last_sub_o) begin
        sub_q <= '0;
        pt_q  <= last_pt_o ? '0 : pt_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && last_sub_o && last_pt_o) |=> (sub_q == '0 && pt_q == '0));
endmodule

// File: rtl/acq_sample_timer.sv
module acq_sample_timer #(
  parameter int SAMPLE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);
  localparam int TW = (SAMPLE_LEN > 1) ? $clog2(SAMPLE_LEN) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= TW'(SAMPLE_LEN - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R4
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> zero_o);
endmodule

// File: rtl/acq_trig_gate.sv
module acq_trig_gate
  import acq_trig_pkg::*;
#(
  parameter int AVG_W       = 4,
  parameter int PTS_W       = 8,
  parameter int SAMPLE_LEN  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             p0_i,
  input  logic             p0_en_i,
  input  logic             cw_mode_i,
  input  logic             subpt_trig_i,
  input  logic [AVG_W-1:0] avg_cnt_i,
  input  logic [PTS_W-1:0] num_pts_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             sweep_done_o
);
  acq_state_e state_q, state_d;
  logic p0_edge, tmr_zero, last_sub, last_pt;
  logic trig, complete, sweep_end, burst_end, load;
  logic start_q, done_q;

  acq_p0_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .p0_i(p0_i), .edge_o(p0_edge)
  );

  acq_sample_timer #(.SAMPLE_LEN(SAMPLE_LEN)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .zero_o(tmr_zero)
  );

  acq_pos_ctr #(.AVG_W(AVG_W), .PTS_W(PTS_W)) pos_i (
    .clk(clk), .rst_n(rst_n), .advance_i(complete),
    .avg_i(avg_cnt_i), .npts_i(num_pts_i),
    .last_sub_o(last_sub), .last_pt_o(last_pt)
  );

  // Acceptance: idle, armed, and a synchronized edge when the pulse line is in use.
  assign trig      = (state_q == ST_IDLE) && arm_i && (!p0_en_i || p0_edge);
  assign complete  = (state_q == ST_SAMPLE) && tmr_zero;
  assign sweep_end = last_sub && last_pt;
  assign burst_end = sweep_end || (!cw_mode_i && (subpt_trig_i || last_sub));
  assign load      = trig || (complete && !burst_end);

  always_comb begin
    state_d = state_q;
    if (trig)                        state_d = ST_SAMPLE;
    else if (complete && burst_end)  state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= load;
      done_q  <= complete && sweep_end;
    end
  end

  assign start_o      = start_q;
  assign busy_o       = (state_q == ST_SAMPLE);
  assign sweep_done_o = done_q;

  // R4
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tmr_zero));

  // R1
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(arm_i));

  // R1
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(p0_en_i)) |-> $past(p0_edge));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done_o |-> !busy_o);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done_o |=> !sweep_done_o);
endmodule

// File: tb/acq_trig_gate_tb_top.sv
module acq_trig_gate_tb_top;
  localparam int AVG_W = 4;
  localparam int PTS_W = 8;
  localparam int SLEN  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b1, p0_i = 1'b0, p0_en_i = 1'b1;
  logic cw_mode_i = 1'b0, subpt_trig_i = 1'b0;
  logic [AVG_W-1:0] avg_cnt_i = 4'd3;
  logic [PTS_W-1:0] num_pts_i = 8'd2;
  logic start_o, busy_o, sweep_done_o;

  int checks = 0;
  int errors = 0;
  int pos_sub = 0;
  int pos_pt  = 0;

  always #5 clk = ~clk;

  acq_trig_gate #(.AVG_W(AVG_W), .PTS_W(PTS_W), .SAMPLE_LEN(SLEN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .p0_i(p0_i), .p0_en_i(p0_en_i),
    .cw_mode_i(cw_mode_i), .subpt_trig_i(subpt_trig_i), .avg_cnt_i(avg_cnt_i),
    .num_pts_i(num_pts_i), .start_o(start_o), .busy_o(busy_o), .sweep_done_o(sweep_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int to_end();
    return (eff(int'(num_pts_i)) - pos_pt) * eff(int'(avg_cnt_i)) - pos_sub;
  endfunction

  function automatic int burst_len();
    if (cw_mode_i) return to_end();
    if (subpt_trig_i) return 1;
    return eff(int'(avg_cnt_i)) - pos_sub;
  endfunction

  task automatic step_pos(input int k);
    for (int i = 0; i < k; i++) begin
      pos_sub++;
      if (pos_sub >= eff(int'(avg_cnt_i))) begin
        pos_sub = 0;
        pos_pt++;
        if (pos_pt >= eff(int'(num_pts_i))) pos_pt = 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    p0_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pos_sub = 0;
    pos_pt = 0;
  endtask

  // Drive p0 for 'width' cycles from cyc 0 and watch one burst.
  task automatic run_burst(input int width, input bit extra, input bit drop_arm,
                           input int arm_rise, input int exp_n, input int exp_lat,
                           input string tag);
    int starts = 0, busy = 0, dones = 0, first = -1, done_cyc = -1, idle = 0;
    bit seen = 0;
    int exp_done;
    exp_done = (exp_n != 0 && exp_n == to_end()) ? 1 : 0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      if (start_o) begin
        starts++;
        if (first < 0) first = cyc;
      end
      if (busy_o) begin busy++; seen = 1; idle = 0; end
      else if (seen) idle++;
      if (sweep_done_o) begin dones++; done_cyc = cyc; end
      p0_i = (cyc < width) || (extra && cyc == first);
      if (cyc == arm_rise) arm_i = 1'b1;
      if (drop_arm && first >= 0) arm_i = 1'b0;
      if (seen && idle >= 3) break;
      if (!seen && cyc >= 12) break;
    end
    p0_i = 1'b0;
    chk(starts == exp_n, tag, starts, exp_n);
    chk(busy == exp_n * SLEN, "R4", busy, exp_n * SLEN);
    chk(dones == exp_done, "R10", dones, exp_done);
    if (exp_n > 0) begin
      chk(first == exp_lat, "R1", first, exp_lat);
      if (exp_done == 1) chk(done_cyc == first + exp_n * SLEN, "R10", done_cyc, first + exp_n * SLEN);
    end
    step_pos(exp_n);
  endtask

  task automatic trig_expect(input int width, input bit extra, input bit drop_arm, input string tag);
    run_burst(width, extra, drop_arm, -1, burst_len(), 3, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R11 reset state
    @(negedge clk);
    chk(!start_o && !busy_o && !sweep_done_o, "R11", {start_o, busy_o, sweep_done_o}, 0);

    // Directed: step mode, 3 sub-points, 2 points
    trig_expect(1, 0, 0, "R5");
    trig_expect(20, 0, 0, "R3");          // long pulse, one burst, sweep end
    trig_expect(1, 1, 0, "R9");           // extra edge during busy
    chk(!busy_o, "R9", busy_o, 0);
    trig_expect(1, 0, 1, "R3");           // arm dropped mid-burst
    arm_i = 1'b0;
    run_burst(1, 0, 0, -1, 0, 3, "R2");   // unarmed edge discarded
    arm_i = 1'b1;
    begin
      int late = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (start_o || busy_o) late++;
      end
      chk(late == 0, "R2", late, 0);
    end
    arm_i = 1'b0;
    run_burst(1, 0, 0, 3, 0, 3, "R2");    // arm raised too late
    arm_i = 1'b0;
    run_burst(1, 0, 0, 0, burst_len(), 3, "R1"); // arm in same cycle as p0
    subpt_trig_i = 1'b1;
    trig_expect(1, 0, 0, "R6");
    trig_expect(3, 0, 0, "R6");
    trig_expect(1, 0, 0, "R6");
    subpt_trig_i = 1'b0;

    // avg 0 treated as 1
    do_reset();
    avg_cnt_i = 4'd0; num_pts_i = 8'd3;
    trig_expect(2, 0, 0, "R5");

    // Continuous-wave sweeps, and point count 0
    do_reset();
    cw_mode_i = 1'b1; avg_cnt_i = 4'd2; num_pts_i = 8'd4;
    trig_expect(1, 0, 0, "R7");
    trig_expect(5, 0, 0, "R7");
    num_pts_i = 8'd0;
    trig_expect(1, 0, 0, "R10");

    // Pulse line disabled: arm alone paces
    do_reset();
    num_pts_i = 8'd3;
    p0_en_i = 1'b0; arm_i = 1'b0;
    p0_i = 1'b1;
    begin
      int cnt = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (busy_o) cnt++;
      end
      chk(cnt == 0, "R8", cnt, 0);
    end
    p0_i = 1'b0;
    arm_i = 1'b1;
    run_burst(0, 0, 1, -1, burst_len(), 0, "R8");
    p0_en_i = 1'b1; arm_i = 1'b1;

    // Constrained random configurations
    for (int c = 0; c < 14; c++) begin
      do_reset();
      cw_mode_i    = ($urandom % 4) == 0;
      subpt_trig_i = 1'($urandom % 2);
      avg_cnt_i    = AVG_W'($urandom % 5);
      num_pts_i    = PTS_W'($urandom % 6);
      for (int t = 0; t < 6; t++) begin
        int w;
        bit x;
        w = 1 + int'($urandom % 8);
        x = (w == 1) && (($urandom % 2) == 1);
        if (cw_mode_i) trig_expect(w, x, 0, "R7");
        else if (subpt_trig_i) trig_expect(w, x, 0, "R6");
        else trig_expect(w, x, 0, "R5");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule